// File: doc/BRIEF.md
# Scaled Framebuffer Video Scan Generator

This block produces the raster timing for an 800x600, 60 Hz display driven by a 40 MHz pixel clock. It runs horizontal and vertical position counters, drives active-high horizontal and vertical sync, and raises a blank flag outside the visible area. While it scans, it forms a read address into an external framebuffer. That framebuffer holds a 16x16 image of 16-bit RGB565 words. Each stored word is shown as a 32x32 block, so the image covers a 512x512 window in the top-left corner of the screen.

The framebuffer sits outside the block. It is a synchronous RAM that returns the addressed word one clock after the address is presented. The block delays its position, sync and blank outputs by that same clock. As a result, every output in a cycle describes the same pixel as the colour bytes. Colour words are widened to 8 bits per channel. Everything outside the 512x512 window is forced to black. The three colour bytes then go to the downstream line encoders.

All timing figures are parameters, as are the replication factor and the image size. The defaults give the 800x600 mode.

Top module: `fbscan_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, every output is zero: `hPos`, `vPos`, `hSync`, `vSync`, `blank`, `fbAddr`, `red`, `green` and `blue`.
- R2: `hPos` counts up by one per clock from 0 to 1055, then returns to 0.
- R3: `vPos` holds steady within a line. It advances by one when `hPos` wraps from 1055, and it returns to 0 after line 627.
- R4: `hSync` is high exactly when 840 <= `hPos` < 968.
- R5: `vSync` is high exactly when 601 <= `vPos` < 605.
- R6: `blank` is high exactly when `hPos` >= 800 or `vPos` >= 600.
- R7: `fbAddr` is a byte address built from the live scan position, one pixel ahead of `hPos`/`vPos`. Bits 8..5 of the vertical position go to address bits 8..5. Bits 8..5 of the horizontal position go to address bits 4..1. Bit 0 and bits 15..9 are zero.
- R8: When bits 11..9 of `hPos` or of `vPos` are not all zero, `red`, `green` and `blue` are zero.
- R9: Inside the window, the RGB565 word is widened as follows. Red is word bits 15..11 followed by bits 15..13. Green is bits 10..5 followed by bits 10..9. Blue is bits 4..0 followed by bits 4..2.
- R10: The colour shown with position (h, v) comes from the word the RAM returned for the address issued one clock earlier. That address is the R7 address of (h, v). Sync and blank in that cycle are the R4 to R6 values for (h, v).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fbAddr | output | 16 | Framebuffer byte read address |
| fbData | input | 16 | RGB565 word from framebuffer, one clock after address |
| hPos | output | 12 | Horizontal position of the pixel on the colour outputs |
| vPos | output | 12 | Vertical position of the pixel on the colour outputs |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the 800x600 active area |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
The assertions check the following on every cycle: the counter stepping and wrap, the sync and blank windows relative to the reported position, the black clip outside the window, and the zero bits of the address. Some behaviour only the bench's scenarios can show. These are that the colour really comes from the word addressed one pixel earlier, that the widening puts every bit in place, and that both sync pulses line up across two whole frames. For this, the bench uses a reduced raster with a 4x replication factor and a bench-side RAM model. A second copy, built with the default parameters, checks the 800-pixel line timing and the 512 clip over the first lines.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  // Strobes from the scan control into the pixel datapath.
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
    logic hSyncNow;
    logic vSyncNow;
    logic activeNow;
    logic inWindow;
  } scanCtl_t;
endpackage

// File: rtl/fbscan_timing.sv
module fbscan_timing
  import fbscan_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int H_ACTIVE   = 800,
  parameter int H_SYNC_BEG = 840,
  parameter int H_SYNC_END = 968,
  parameter int H_TOTAL    = 1056,
  parameter int V_ACTIVE   = 600,
  parameter int V_SYNC_BEG = 601,
  parameter int V_SYNC_END = 605,
  parameter int V_TOTAL    = 628,
  parameter int WIN_BITS   = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output scanCtl_t         ctl
);
  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(H_TOTAL - 1);
  localparam logic [CNT_W-1:0] V_LAST = CNT_W'(V_TOTAL - 1);
  localparam logic [CNT_W-1:0] H_ACT  = CNT_W'(H_ACTIVE);
  localparam logic [CNT_W-1:0] V_ACT  = CNT_W'(V_ACTIVE);
  localparam logic [CNT_W-1:0] H_SB   = CNT_W'(H_SYNC_BEG);
  localparam logic [CNT_W-1:0] H_SE   = CNT_W'(H_SYNC_END);
  localparam logic [CNT_W-1:0] V_SB   = CNT_W'(V_SYNC_BEG);
  localparam logic [CNT_W-1:0] V_SE   = CNT_W'(V_SYNC_END);

  always_comb begin
    ctl.lineEnd   = (hCnt == H_LAST);
    ctl.frameEnd  = ctl.lineEnd && (vCnt == V_LAST);
    ctl.hSyncNow  = (hCnt >= H_SB) && (hCnt < H_SE);
    ctl.vSyncNow  = (vCnt >= V_SB) && (vCnt < V_SE);
    ctl.activeNow = (hCnt < H_ACT) && (vCnt < V_ACT);
    ctl.inWindow  = ((hCnt >> WIN_BITS) == '0) && ((vCnt >> WIN_BITS) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (ctl.frameEnd) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (ctl.lineEnd) begin
      hCnt <= '0;
      vCnt <= vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbscan_pixel.sv
module fbscan_pixel
  import fbscan_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 16,
  parameter int TILE_SHIFT = 5,
  parameter int IMG_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  hCnt,
  input  logic [CNT_W-1:0]  vCnt,
  input  scanCtl_t          ctl,
  output logic [ADDR_W-1:0] fbAddr,
  input  logic [15:0]       fbData,
  output logic [CNT_W-1:0]  hPos,
  output logic [CNT_W-1:0]  vPos,
  output logic              hSync,
  output logic              vSync,
  output logic              blank,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);
  localparam int TOP = TILE_SHIFT + IMG_BITS - 1;

  logic       winQ;
  logic [4:0] r5;
  logic [5:0] g6;
  logic [4:0] b5;

  // Tile index pair, word aligned.
  assign fbAddr = ADDR_W'({vCnt[TOP:TILE_SHIFT], hCnt[TOP:TILE_SHIFT], 1'b0});

  // One stage to match the RAM read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      hPos  <= '0;
      vPos  <= '0;
      hSync <= 1'b0;
      vSync <= 1'b0;
      blank <= 1'b0;
      winQ  <= 1'b0;
    end else begin
      hPos  <= hCnt;
      vPos  <= vCnt;
      hSync <= ctl.hSyncNow;
      vSync <= ctl.vSyncNow;
      blank <= !ctl.activeNow;
      winQ  <= ctl.inWindow;
    end
  end

  assign r5 = fbData[15:11];
  assign g6 = fbData[10:5];
  assign b5 = fbData[4:0];

  always_comb begin
    if (winQ) begin
      red   = {r5, r5[4:2]};
      green = {g6, g6[5:4]};
      blue  = {b5, b5[4:2]};
    end else begin
      red   = '0;
      green = '0;
      blue  = '0;
    end
  end
endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 16,
  parameter int H_ACTIVE   = 800,
  parameter int H_SYNC_BEG = 840,
  parameter int H_SYNC_END = 968,
  parameter int H_TOTAL    = 1056,
  parameter int V_ACTIVE   = 600,
  parameter int V_SYNC_BEG = 601,
  parameter int V_SYNC_END = 605,
  parameter int V_TOTAL    = 628,
  parameter int TILE_SHIFT = 5,
  parameter int IMG_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] fbAddr,
  input  logic [15:0]       fbData,
  output logic [CNT_W-1:0]  hPos,
  output logic [CNT_W-1:0]  vPos,
  output logic              hSync,
  output logic              vSync,
  output logic              blank,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);
  localparam int WIN_BITS = TILE_SHIFT + IMG_BITS;

  logic [CNT_W-1:0] hCnt;
  logic [CNT_W-1:0] vCnt;
  scanCtl_t         ctl;

  fbscan_timing #(
    .CNT_W(CNT_W), .H_ACTIVE(H_ACTIVE), .H_SYNC_BEG(H_SYNC_BEG),
    .H_SYNC_END(H_SYNC_END), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE),
    .V_SYNC_BEG(V_SYNC_BEG), .V_SYNC_END(V_SYNC_END), .V_TOTAL(V_TOTAL),
    .WIN_BITS(WIN_BITS)
  ) u_timing (
    .clk(clk), .rst(rst), .hCnt(hCnt), .vCnt(vCnt), .ctl(ctl)
  );

  fbscan_pixel #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .TILE_SHIFT(TILE_SHIFT), .IMG_BITS(IMG_BITS)
  ) u_pixel (
    .clk(clk), .rst(rst), .hCnt(hCnt), .vCnt(vCnt), .ctl(ctl),
    .fbAddr(fbAddr), .fbData(fbData), .hPos(hPos), .vPos(vPos),
    .hSync(hSync), .vSync(vSync), .blank(blank),
    .red(red), .green(green), .blue(blue)
  );
endmodule

// File: rtl/fbscan_chk.sv
module fbscan_chk #(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 16,
  parameter int H_ACTIVE   = 800,
  parameter int H_SYNC_BEG = 840,
  parameter int H_SYNC_END = 968,
  parameter int H_TOTAL    = 1056,
  parameter int V_ACTIVE   = 600,
  parameter int V_SYNC_BEG = 601,
  parameter int V_SYNC_END = 605,
  parameter int V_TOTAL    = 628,
  parameter int TILE_SHIFT = 5,
  parameter int IMG_BITS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fbAddr,
  input logic [CNT_W-1:0]  hPos,
  input logic [CNT_W-1:0]  vPos,
  input logic              hSync,
  input logic              vSync,
  input logic              blank,
  input logic [7:0]        red,
  input logic [7:0]        green,
  input logic [7:0]        blue
);
  localparam int WIN_BITS = TILE_SHIFT + IMG_BITS;
  localparam int ADDR_USED = 2 * IMG_BITS + 1;
  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(H_TOTAL - 1);
  localparam logic [CNT_W-1:0] V_LAST = CNT_W'(V_TOTAL - 1);

  p_hstep_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hPos != H_LAST) |=> hPos == $past(hPos) + 1'b1);

  p_hwrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hPos == H_LAST) |=> hPos == '0);

  p_vhold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hPos != H_LAST) |=> $stable(vPos));

  p_vwrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hPos == H_LAST && vPos == V_LAST) |=> vPos == '0);

  p_hsync_r4: assert property (@(posedge clk) disable iff (rst)
    hSync == (hPos >= CNT_W'(H_SYNC_BEG) && hPos < CNT_W'(H_SYNC_END)));

  p_vsync_r5: assert property (@(posedge clk) disable iff (rst)
    vSync == (vPos >= CNT_W'(V_SYNC_BEG) && vPos < CNT_W'(V_SYNC_END)));

  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    blank == (hPos >= CNT_W'(H_ACTIVE) || vPos >= CNT_W'(V_ACTIVE)));

  p_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (fbAddr[0] == 1'b0) && ((fbAddr >> ADDR_USED) == '0));

  p_clip_r8: assert property (@(posedge clk) disable iff (rst)
    ((hPos >> WIN_BITS) != '0 || (vPos >> WIN_BITS) != '0)
      |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0));
endmodule

bind fbscan_top fbscan_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .H_ACTIVE(H_ACTIVE), .H_SYNC_BEG(H_SYNC_BEG),
  .H_SYNC_END(H_SYNC_END), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE),
  .V_SYNC_BEG(V_SYNC_BEG), .V_SYNC_END(V_SYNC_END), .V_TOTAL(V_TOTAL),
  .TILE_SHIFT(TILE_SHIFT), .IMG_BITS(IMG_BITS)
) i_chk (
  .clk(clk), .rst(rst), .fbAddr(fbAddr), .hPos(hPos), .vPos(vPos),
  .hSync(hSync), .vSync(vSync), .blank(blank),
  .red(red), .green(green), .blue(blue)
);

// File: tb/test_fbscan_top.sv
module test_fbscan_top;
  // Reduced raster for the scoreboard instance.
  localparam int HA = 80, HSB = 84, HSE = 92, HT = 100;
  localparam int VA = 70, VSB = 71, VSE = 73, VT = 76;
  localparam int TS = 2, IB = 4, WB = TS + IB;

  typedef struct {
    int h; int v; bit hs; bit vs; bit bl;
    int r; int g; int b; int nextAddr;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] fbAddr, fbData, fbAddrF;
  logic [11:0] hPos, vPos, hPosF, vPosF;
  logic hSync, vSync, blank, hSyncF, vSyncF, blankF;
  logic [7:0] red, green, blue, redF, greenF, blueF;

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit running = 1'b0;
  item_t sbq[$];

  fbscan_top #(
    .H_ACTIVE(HA), .H_SYNC_BEG(HSB), .H_SYNC_END(HSE), .H_TOTAL(HT),
    .V_ACTIVE(VA), .V_SYNC_BEG(VSB), .V_SYNC_END(VSE), .V_TOTAL(VT),
    .TILE_SHIFT(TS), .IMG_BITS(IB)
  ) i_fbscan_top (
    .clk(clk), .rst(rst), .fbAddr(fbAddr), .fbData(fbData),
    .hPos(hPos), .vPos(vPos), .hSync(hSync), .vSync(vSync), .blank(blank),
    .red(red), .green(green), .blue(blue)
  );

  fbscan_top i_fbscan_top_full (
    .clk(clk), .rst(rst), .fbAddr(fbAddrF), .fbData(16'hFFFF),
    .hPos(hPosF), .vPos(vPosF), .hSync(hSyncF), .vSync(vSyncF), .blank(blankF),
    .red(redF), .green(greenF), .blue(blueF)
  );

  function automatic logic [15:0] pattern(input int idx);
    logic [15:0] p;
    p = 16'(idx * 40503);
    return p ^ 16'h5A5A;
  endfunction

  // Synchronous RAM model: word available one clock after the address.
  always @(posedge clk) fbData <= pattern(int'(fbAddr[8:1]));

  function automatic int addrOf(input int h, input int v);
    return (((v >> TS) % (1 << IB)) << (IB + 1)) | (((h >> TS) % (1 << IB)) << 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: one expected item per pixel, in scan order.
  task automatic drivePixels(input int count);
    int h = 0, v = 0;
    for (int n = 0; n < count; n++) begin
      item_t it;
      int nh, nv;
      logic [15:0] w;
      @(posedge clk);
      #1;
      nh = (h == HT - 1) ? 0 : h + 1;
      nv = (h == HT - 1) ? ((v == VT - 1) ? 0 : v + 1) : v;
      it.h = h; it.v = v;
      it.hs = (h >= HSB && h < HSE);
      it.vs = (v >= VSB && v < VSE);
      it.bl = (h >= HA || v >= VA);
      w = pattern(addrOf(h, v) >> 1);
      if (h < (1 << WB) && v < (1 << WB)) begin
        it.r = {w[15:11], w[15:13]};
        it.g = {w[10:5], w[10:9]};
        it.b = {w[4:0], w[4:2]};
      end else begin
        it.r = 0; it.g = 0; it.b = 0;
      end
      it.nextAddr = addrOf(nh, nv);
      sbq.push_back(it);
      h = nh; v = nv;
    end
  endtask

  // Monitor: compares each produced pixel against the queue head.
  initial begin
    int prevH = 0;
    bit havePrev = 1'b0;
    wait (running);
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t e;
        e = sbq.pop_front();
        check(hPos == 12'(e.h), "R2", "hPos", int'(hPos), e.h);
        check(vPos == 12'(e.v), "R3", "vPos", int'(vPos), e.v);
        check(hSync == e.hs, "R4", "hSync", int'(hSync), int'(e.hs));
        check(vSync == e.vs, "R5", "vSync", int'(vSync), int'(e.vs));
        check(blank == e.bl, "R6", "blank", int'(blank), int'(e.bl));
        check(fbAddr == 16'(e.nextAddr), "R7", "fbAddr", int'(fbAddr), e.nextAddr);
        if (e.h >= (1 << WB) || e.v >= (1 << WB))
          check(red == 0 && green == 0 && blue == 0, "R8", "clip",
                int'({red, green, blue}), 0);
        else begin
          check(red == 8'(e.r), "R9/R10", "red", int'(red), e.r);
          check(green == 8'(e.g), "R9/R10", "green", int'(green), e.g);
          check(blue == 8'(e.b), "R9/R10", "blue", int'(blue), e.b);
        end
      end
      // Default-parameter copy: 800x600 line timing and 512 clip.
      if (!rst) begin
        check(hSyncF == (hPosF >= 840 && hPosF < 968), "R4", "full hSync",
              int'(hSyncF), int'(hPosF >= 840 && hPosF < 968));
        check(blankF == (hPosF >= 800 || vPosF >= 600), "R6", "full blank",
              int'(blankF), int'(hPosF >= 800 || vPosF >= 600));
        check(vSyncF == 1'b0, "R5", "full vSync early lines", int'(vSyncF), 0);
        if (hPosF < 512 && vPosF < 512)
          check(redF == 8'hFF && greenF == 8'hFF && blueF == 8'hFF, "R9",
                "full white", int'(redF), 255);
        else
          check(redF == 0 && greenF == 0 && blueF == 0, "R8", "full clip",
                int'(redF), 0);
        if (havePrev)
          check(int'(hPosF) == ((prevH == 1055) ? 0 : prevH + 1), "R2", "full hPos step",
                int'(hPosF), (prevH == 1055) ? 0 : prevH + 1);
        prevH = int'(hPosF);
        havePrev = 1'b1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hPos == 0 && vPos == 0, "R1", "position in reset", int'(hPos) + int'(vPos), 0);
    check(hSync == 0 && vSync == 0 && blank == 0, "R1", "flags in reset",
          int'({hSync, vSync, blank}), 0);
    check(fbAddr == 0, "R1", "fbAddr in reset", int'(fbAddr), 0);
    check(red == 0 && green == 0 && blue == 0, "R1", "colour in reset",
          int'({red, green, blue}), 0);
    rst = 1'b0;
    running = 1'b1;
    // Two whole reduced frames plus a few lines.
    drivePixels(2 * HT * VT + 3 * HT);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule